// File: doc/BRIEF.md
# Vector Branch Length Truncation Unit

This block walks the elements of a vector conditional branch, one element per clock, and finds the first element whose branch outcome matches a chosen sense. At that element it cuts the active vector length short, so that later vector work only covers the elements before the exit point, or up to and including it. While walking, it can also step a loop count down, one element at a time, depending on each element's outcome. At the end it reports whether the final branch was taken and whether the link register may be written.

A one-cycle `start` pulse captures all inputs: the current length, a per-element predicate mask, per-element condition results, the count value and the mode bits. The state machine has three states. `ST_IDLE` waits for `start`. `ST_WALK` evaluates one element per cycle. `ST_DONE` raises `done` for one cycle. The transitions are named:

- `IDLE->WALK` on `start`.
- `WALK->WALK` while the element is skipped, or is tested and does not trigger.
- `WALK->DONE` when an element triggers, or when the index reaches the length.
- `DONE->IDLE` unconditionally.

Only the active length is produced. Any maximum length held elsewhere is not an output.

Top module: `vec_branch_trunc`

## Requirements
- R1: Elements are visited from index 0 upward. An element whose predicate bit is 0, or whose index is at or past the length, is never tested. Such an element cannot trigger and cannot change the count or the taken flag.
- R2: With `sense_taken`=1, a tested element triggers when its `cond_bits` bit is 1. With `sense_taken`=0, it triggers when that bit is 0.
- R3: With `incl_mode`=1, a trigger at index i gives `len_out` = i+1, whatever `zero_mode` is.
- R4: With `incl_mode`=0 and `zero_mode`=0, a trigger gives `len_out` = one past the last tested element before it, or 0 if no element was tested before it. For example, mask 0b110010 with a trigger at element 4 gives 2.
- R5: With `incl_mode`=0 and `zero_mode`=1, a trigger at index i gives `len_out` = i.
- R6: If no element triggers, `len_out` equals `vl_in`, clamped to MAX_ELEMS.
- R7: When `cnt_dec_en`=1, each tested element decrements the count by one when (cond XOR `cnt_dec_inv`) is 1. A triggering element in exclusive mode does not decrement; in inclusive mode it does.
- R8: `taken` is the condition bit of the last tested element, or 0 if none was tested. `link_upd` = `link_req` AND `taken`.
- R9: `done` is high for exactly one cycle per run. The results stay valid from then until the next accepted start.
- R10: `start` is ignored while a run is in progress.
- R11: After reset, `done`, `len_out`, `cnt_out`, `taken` and `link_upd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; inputs are captured on this cycle |
| vl_in | input | LEN_W | Current vector length |
| pred_mask | input | MAX_ELEMS | Predicate bit per element |
| cond_bits | input | MAX_ELEMS | Branch condition result per element (1 = taken) |
| cnt_in | input | CNT_W | Count value at start |
| incl_mode | input | 1 | Keep the triggering element in the new length |
| sense_taken | input | 1 | 1: trigger on taken, 0: trigger on not taken |
| zero_mode | input | 1 | Masked-off elements still count toward length |
| cnt_dec_en | input | 1 | Enable the count decrement |
| cnt_dec_inv | input | 1 | Decrement on failure instead of success |
| link_req | input | 1 | Link update requested by the branch |
| done | output | 1 | One-cycle completion pulse |
| len_out | output | LEN_W | Truncated vector length |
| cnt_out | output | CNT_W | Updated count |
| taken | output | 1 | Final branch decision |
| link_upd | output | 1 | Link register write enable |

## Verification
The bench sweeps every 6-bit predicate mask against several condition patterns and all eight combinations of inclusive, sense and zeroing. This catches a design that counts skipped elements toward the exclusive length when zeroing is off; on the 0b110010 example it would report 4 instead of 2. It also catches a design that decrements the count on an exclusive trigger, which leaves the count one low, and one that applies the sense backwards, which truncates at the wrong element. Directed runs cover:

- a zero length, where nothing is tested and the result is 0;
- an oversized length clamped to the maximum;
- a trigger at element 0 in exclusive mode, which gives length 0;
- a second start during a run, which would corrupt the first run's results if it were accepted.

// File: rtl/vbt_pkg.sv
package vbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_DONE
    } vbt_state_t;

    typedef enum logic [1:0] {
        ACT_END,
        ACT_SKIP,
        ACT_PASS,
        ACT_TRIG
    } vbt_act_t;

    typedef struct packed {
        logic incl;
        logic sense;
        logic zero;
        logic cnt_en;
        logic cnt_inv;
    } vbt_mode_t;

endpackage

// File: rtl/vbt_elem_eval.sv
module vbt_elem_eval
    import vbt_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] vl,
    input  logic [LEN_W-1:0] kept,
    input  logic             pred_bit,
    input  logic             cond_bit,
    input  vbt_mode_t        mode,
    output vbt_act_t         act,
    output logic             dec_req,
    output logic [LEN_W-1:0] trig_len
);

    logic in_range;
    logic tested;
    logic hit;

    always_comb begin
        in_range = (idx < vl);
        tested   = in_range && pred_bit;
        hit      = tested && (cond_bit == mode.sense);

        if (!in_range)
            act = ACT_END;
        else if (!pred_bit)
            act = ACT_SKIP;
        else if (hit)
            act = ACT_TRIG;
        else
            act = ACT_PASS;

        // an exclusive trigger ends the walk before any count step
        dec_req = tested && mode.cnt_en && (cond_bit ^ mode.cnt_inv)
                  && !(hit && !mode.incl);

        if (mode.incl)
            trig_len = idx + LEN_W'(1);
        else if (mode.zero)
            trig_len = idx;
        else
            trig_len = kept;
    end

endmodule

// File: rtl/vbt_cnt_step.sv
module vbt_cnt_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             dec,
    output logic [CNT_W-1:0] nxt
);

    always_comb begin
        nxt = dec ? (cur - CNT_W'(1)) : cur;
    end

endmodule

// File: rtl/vec_branch_trunc.sv
module vec_branch_trunc
    import vbt_pkg::*;
#(
    parameter int MAX_ELEMS = 64,
    parameter int CNT_W     = 16,
    parameter int LEN_W     = $clog2(MAX_ELEMS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LEN_W-1:0]     vl_in,
    input  logic [MAX_ELEMS-1:0] pred_mask,
    input  logic [MAX_ELEMS-1:0] cond_bits,
    input  logic [CNT_W-1:0]     cnt_in,
    input  logic                 incl_mode,
    input  logic                 sense_taken,
    input  logic                 zero_mode,
    input  logic                 cnt_dec_en,
    input  logic                 cnt_dec_inv,
    input  logic                 link_req,
    output logic                 done,
    output logic [LEN_W-1:0]     len_out,
    output logic [CNT_W-1:0]     cnt_out,
    output logic                 taken,
    output logic                 link_upd
);

    localparam int IDX_W = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_ELEMS);

    vbt_state_t state_q, state_d;

    logic [MAX_ELEMS-1:0] pred_q;
    logic [MAX_ELEMS-1:0] cond_q;
    logic [LEN_W-1:0]     vl_q;
    logic [LEN_W-1:0]     idx_q;
    logic [LEN_W-1:0]     kept_q;
    logic [LEN_W-1:0]     len_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 taken_q;
    logic                 link_q;
    vbt_mode_t            mode_q;

    logic [LEN_W-1:0]     vl_clamped;
    logic [IDX_W-1:0]     sel;
    logic                 pred_cur;
    logic                 cond_cur;
    vbt_act_t             act;
    logic                 dec_req;
    logic [LEN_W-1:0]     trig_len;
    logic [CNT_W-1:0]     cnt_nxt;

    assign vl_clamped = (vl_in > LEN_MAX) ? LEN_MAX : vl_in;
    assign sel        = idx_q[IDX_W-1:0];
    assign pred_cur   = pred_q[sel];
    assign cond_cur   = cond_q[sel];

    vbt_elem_eval #(.LEN_W(LEN_W)) u_eval (
        .idx      (idx_q),
        .vl       (vl_q),
        .kept     (kept_q),
        .pred_bit (pred_cur),
        .cond_bit (cond_cur),
        .mode     (mode_q),
        .act      (act),
        .dec_req  (dec_req),
        .trig_len (trig_len)
    );

    vbt_cnt_step #(.CNT_W(CNT_W)) u_cnt (
        .cur (cnt_q),
        .dec (dec_req),
        .nxt (cnt_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WALK;
            ST_WALK: if (act == ACT_END || act == ACT_TRIG) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q  <= '0;
            cond_q  <= '0;
            vl_q    <= '0;
            idx_q   <= '0;
            kept_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            taken_q <= 1'b0;
            link_q  <= 1'b0;
            mode_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pred_q  <= pred_mask;
                        cond_q  <= cond_bits;
                        vl_q    <= vl_clamped;
                        idx_q   <= '0;
                        kept_q  <= '0;
                        cnt_q   <= cnt_in;
                        taken_q <= 1'b0;
                        link_q  <= link_req;
                        mode_q  <= '{incl:    incl_mode,
                                     sense:   sense_taken,
                                     zero:    zero_mode,
                                     cnt_en:  cnt_dec_en,
                                     cnt_inv: cnt_dec_inv};
                    end
                end
                ST_WALK: begin
                    unique case (act)
                        ACT_END: begin
                            len_q <= vl_q;
                        end
                        ACT_SKIP: begin
                            idx_q <= idx_q + LEN_W'(1);
                        end
                        ACT_PASS: begin
                            idx_q   <= idx_q + LEN_W'(1);
                            kept_q  <= idx_q + LEN_W'(1);
                            taken_q <= cond_cur;
                            cnt_q   <= cnt_nxt;
                        end
                        ACT_TRIG: begin
                            taken_q <= cond_cur;
                            cnt_q   <= cnt_nxt;
                            len_q   <= trig_len;
                        end
                        default: ;
                    endcase
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done     = (state_q == ST_DONE);
        len_out  = len_q;
        cnt_out  = cnt_q;
        taken    = taken_q;
        link_upd = taken_q && link_q;
    end

endmodule

// File: rtl/vbt_checker.sv
module vbt_checker #(
    parameter int LEN_W = 7,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             in_walk,
    input logic [LEN_W-1:0] len_out,
    input logic [LEN_W-1:0] vl_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             taken,
    input logic             link_upd
);

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done only follows a walk
    assert_done_after_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_walk));

    // R6: the reported length never exceeds the captured length
    assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len_out <= vl_q));

    // R10: captured length is frozen during a walk
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_walk |=> $stable(vl_q));

    // R7: the count moves down by at most one per element
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_walk |=> (cnt_q == $past(cnt_q) || cnt_q == ($past(cnt_q) - CNT_W'(1))));

    // R8: link update implies a taken branch
    assert_link_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_upd |-> taken);

endmodule

bind vec_branch_trunc vbt_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_vbt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .in_walk  (state_q == vbt_pkg::ST_WALK),
    .len_out  (len_out),
    .vl_q     (vl_q),
    .cnt_q    (cnt_q),
    .taken    (taken),
    .link_upd (link_upd)
);

// File: tb/vec_branch_trunc_bench.sv
module vec_branch_trunc_bench;

    localparam int ME = 64;
    localparam int CW = 16;
    localparam int LW = $clog2(ME + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] vl_in = '0;
    logic [ME-1:0] pred_mask = '0;
    logic [ME-1:0] cond_bits = '0;
    logic [CW-1:0] cnt_in = '0;
    logic          incl_mode = 1'b0, sense_taken = 1'b0, zero_mode = 1'b0;
    logic          cnt_dec_en = 1'b0, cnt_dec_inv = 1'b0, link_req = 1'b0;
    logic          done, taken, link_upd;
    logic [LW-1:0] len_out;
    logic [CW-1:0] cnt_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    vec_branch_trunc #(.MAX_ELEMS(ME), .CNT_W(CW)) u_vec_branch_trunc (
        .clk, .rst_n, .start, .vl_in, .pred_mask, .cond_bits, .cnt_in,
        .incl_mode, .sense_taken, .zero_mode, .cnt_dec_en, .cnt_dec_inv,
        .link_req, .done, .len_out, .cnt_out, .taken, .link_upd
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected results derived from the requirements
    task automatic expect_of(input int vl, input logic [ME-1:0] m, input logic [ME-1:0] c,
                             input int cnt, input logic inc, input logic sen, input logic zer,
                             input logic cen, input logic cinv,
                             output int e_len, output int e_cnt, output logic e_tk);
        int lim;
        int last;
        bit stop;
        lim = (vl > ME) ? ME : vl;
        last = 0; e_cnt = cnt; e_tk = 1'b0; e_len = lim; stop = 0;
        for (int i = 0; i < lim && !stop; i++) begin
            if (m[i]) begin
                e_tk = c[i];
                if (c[i] == sen && !inc) begin
                    e_len = zer ? i : last;
                    stop = 1;
                end else begin
                    if (cen && (c[i] ^ cinv)) e_cnt = (e_cnt - 1) & 32'hFFFF;
                    if (c[i] == sen) begin
                        e_len = i + 1;
                        stop = 1;
                    end
                    last = i + 1;
                end
            end
        end
    endtask

    task automatic launch(input int vl, input logic [ME-1:0] m, input logic [ME-1:0] c,
                          input int cnt, input logic inc, input logic sen, input logic zer,
                          input logic cen, input logic cinv, input logic lreq);
        @(negedge clk);
        vl_in = LW'(vl); pred_mask = m; cond_bits = c; cnt_in = CW'(cnt);
        incl_mode = inc; sense_taken = sen; zero_mode = zer;
        cnt_dec_en = cen; cnt_dec_inv = cinv; link_req = lreq;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int n;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        ok = done;
    endtask

    task automatic run_case(input string tag, input int vl, input logic [ME-1:0] m,
                            input logic [ME-1:0] c, input int cnt, input logic inc,
                            input logic sen, input logic zer, input logic cen,
                            input logic cinv, input logic lreq);
        int e_len, e_cnt;
        logic e_tk;
        bit ok;
        expect_of(vl, m, c, cnt, inc, sen, zer, cen, cinv, e_len, e_cnt, e_tk);
        launch(vl, m, c, cnt, inc, sen, zer, cen, cinv, lreq);
        wait_done(ok);
        chk({tag, " R9 done seen"}, ok, 1);
        chk({tag, " len R3/R4/R5/R6"}, len_out, e_len);
        chk({tag, " cnt R7"}, cnt_out, e_cnt);
        chk({tag, " taken R8"}, taken, e_tk);
        chk({tag, " link R8"}, link_upd, lreq & e_tk);
        @(negedge clk);
        chk({tag, " pulse R9"}, done, 0);
        chk({tag, " hold R9"}, len_out, e_len);
    endtask

    initial begin
        logic [ME-1:0] pats [3];
        int e_len, e_cnt;
        logic e_tk;
        bit ok;
        pats[0] = 64'hA5C3_0F96_3C5A_E12D;
        pats[1] = 64'h5A3C_F069_C3A5_1ED2;
        pats[2] = 64'h0000_0000_0000_0013;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done", done, 0);
        chk("R11 len", len_out, 0);
        chk("R11 cnt", cnt_out, 0);
        chk("R11 taken", taken, 0);
        chk("R11 link", link_upd, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 example: mask 0b110010, element 1 taken, element 4 not taken, sense not-taken
        run_case("R4 example", 6, 64'b110010, 64'b000010, 9, 0, 0, 0, 1, 0, 1);
        chk("R4 example len", len_out, 2);
        run_case("R5 example", 6, 64'b110010, 64'b000010, 9, 0, 0, 1, 1, 0, 1);
        chk("R5 example len", len_out, 4);
        run_case("R3 example", 6, 64'b110010, 64'b000010, 9, 1, 0, 0, 1, 0, 1);
        chk("R3 example len", len_out, 5);

        // R1 zero length: nothing tested
        run_case("R1 vl0", 0, '1, '1, 7, 1, 1, 0, 1, 0, 1);
        chk("R1 vl0 len", len_out, 0);
        // R6 clamp of oversized length, no trigger
        run_case("R6 clamp", 100, '1, '1, 200, 0, 0, 0, 1, 0, 1);
        chk("R6 clamp len", len_out, ME);
        chk("R7 full count", cnt_out, 200 - ME);
        // R2 trigger at element 0 exclusive
        run_case("R2 first", 8, '1, 64'h1, 5, 0, 1, 0, 1, 0, 0);
        chk("R2 first len", len_out, 0);

        // R10 start during a walk is ignored
        expect_of(20, '1, '0, 50, 0, 1, 0, 1, 1, e_len, e_cnt, e_tk);
        launch(20, '1, '0, 50, 0, 1, 0, 1, 1, 0);
        repeat (3) @(negedge clk);
        vl_in = LW'(3); cnt_in = CW'(7); cond_bits = '1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk("R10 done", ok, 1);
        chk("R10 len", len_out, e_len);
        chk("R10 cnt", cnt_out, e_cnt);
        repeat (2) @(negedge clk);

        // sweep: all 6-bit masks x condition patterns x mode combinations
        for (int m = 0; m < 64; m++) begin
            for (int p = 0; p < 3; p++) begin
                for (int md = 0; md < 8; md++) begin
                    run_case("sweep R1 R2", 6, {58'h2AB_CDEF_0123_4567, 6'(m)}, pats[p],
                             1000, md[0], md[1], md[2], 1'b1, m[0] ^ p[0], m[1]);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule